// File: doc/BRIEF.md
# Serial Management Slave with Preamble Suppression

This block is the device-side agent of a two-wire serial management bus. A station manager drives a management clock and a shared, bidirectional data line that idles high through an external pull-up; up to 32 devices hang on the same line. The agent samples the line on every rising clock edge. It looks for a start pattern of `01`, then collects a 2-bit opcode, a 5-bit device address and a 5-bit register address, all most-significant bit first. When the device address matches the value strapped at reset and the opcode is read or write, it serves the frame against a bank of 32 registers of 16 bits each.

A frame needs no run of 32 preamble ones: one high idle bit before the start pattern is enough, so frames may follow each other with a single idle bit between them. A frame that does carry a long preamble is also accepted. On a read, the agent leaves the line released for the first turnaround bit, drives a 0 for the second, then drives the 16 data bits and releases the line again. On a write, the manager drives everything and the agent only stores the data. Frames for other addresses, and frames with a reserved opcode, are skipped in full without touching the line or the register bank.

Top module: `mdio_mgmt_agent`

## Requirements
- R1: After reset the driver enable `mdio_oe` is low and stays low while no read is being served. Register 0 reads back 0x1140 and every other register reads back 0x0000.
- R2: A frame is recognised when it begins after a single idle (1) bit with no preamble, so two frames separated by exactly one idle bit are both served.
- R3: A frame that is preceded by 32 or more idle ones is served the same way as one without a preamble.
- R4: A frame with opcode `01` (write) whose address matches stores the 16 data bits, sent MSB first, into the addressed register. `mdio_oe` stays low for the whole frame.
- R5: A frame with opcode `10` (read) whose address matches leaves `mdio_oe` low through bit 15 of the frame (the first turnaround bit). It drives 0 for bit 16 and register bits 15 down to 0 for bits 17 to 32. Each driven value appears just after the preceding rising edge, so `mdio_oe` is high for exactly 17 sampled bits. The line is released after bit 32.
- R6: A frame whose 5-bit address differs from the latched address is skipped in full: nothing is driven and no register changes.
- R7: A frame with opcode `00` or `11` is skipped in full: nothing is driven and no register changes.
- R8: The device address is the value on `phy_addr_strap` during reset. Changing the strap after reset has no effect until the next reset, and a new reset also reloads the register reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock from the station manager; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset; also latches the address strap |
| phy_addr_strap | input | 5 | Device address strap, sampled while `rst` is high |
| mdio_in | input | 1 | Sampled value of the shared data line |
| mdio_out | output | 1 | Value the agent drives onto the line when enabled |
| mdio_oe | output | 1 | Driver enable for the shared line; low means released |

## Verification
Frame state that goes wrong shows up on the line within one frame. A slip in the bit counter moves the rising edge of `mdio_oe` or shifts the read data by one bit on the next read. A wrong address or opcode decision either drives a frame that should be silent, which is seen on the very bit after the turnaround, or leaves a read undriven. A corrupt register write or a missed skip stays hidden until the affected register is read back, so every write and every ignored frame is followed by a read of the same register.

// File: rtl/mdio_agent_pkg.sv
package mdio_agent_pkg;

    localparam int DEV_ADDR_W = 5;
    localparam int REG_ADDR_W = 5;
    localparam int REG_W      = 16;
    localparam int OPC_W      = 2;
    localparam int TURN_BITS  = 2;
    localparam int HDR_W      = OPC_W + DEV_ADDR_W + REG_ADDR_W;
    localparam int DRIVE_BITS = REG_W + 1;

    typedef enum logic [2:0] {
        ST_WAIT_IDLE,
        ST_READY,
        ST_START,
        ST_HDR,
        ST_TURN,
        ST_DATA,
        ST_SKIP
    } fsm_state_e;

    typedef enum logic [OPC_W-1:0] {
        OPC_RSVD_LO = 2'b00,
        OPC_WRITE   = 2'b01,
        OPC_READ    = 2'b10,
        OPC_RSVD_HI = 2'b11
    } opcode_e;

    typedef struct packed {
        opcode_e                 op;
        logic [DEV_ADDR_W-1:0]   dev;
        logic [REG_ADDR_W-1:0]   reg_idx;
    } frame_hdr_t;

    function automatic logic [REG_W-1:0] reg_reset_value(input int idx);
        return (idx == 0) ? REG_W'(16'h1140) : '0;
    endfunction

endpackage

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_agent_pkg::*;
#(
    parameter int AW  = DEV_ADDR_W,
    parameter int RAW = REG_ADDR_W,
    parameter int DW  = REG_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           din,
    input  logic [AW-1:0]  my_addr,
    output fsm_state_e     state,
    output logic           wr_en,
    output logic [RAW-1:0] reg_idx,
    output logic [DW-1:0]  wr_data,
    output logic           drv_start,
    output logic           drv_stop
);

    localparam int HW    = OPC_W + AW + RAW;
    localparam int SKIPN = TURN_BITS + DW;
    localparam int CNT_W = $clog2(HW + SKIPN + 1);

    fsm_state_e     st;
    logic [CNT_W-1:0] cnt;
    logic [HW-1:0]  hdr_sh;
    logic [DW-1:0]  data_sh;
    logic [RAW-1:0] idx_q;
    logic           is_read;

    logic [HW-1:0]  hdr_full;
    logic [OPC_W-1:0] op_f;
    logic [AW-1:0]  dev_f;
    logic [RAW-1:0] idx_f;
    logic           op_ok;
    logic           hit;
    logic           data_last;

    always_comb begin
        hdr_full  = {hdr_sh[HW-2:0], din};
        op_f      = hdr_full[HW-1 -: OPC_W];
        dev_f     = hdr_full[RAW +: AW];
        idx_f     = hdr_full[RAW-1:0];
        op_ok     = (op_f == OPC_READ) || (op_f == OPC_WRITE);
        hit       = op_ok && (dev_f == my_addr);
        data_last = (st == ST_DATA) && (cnt == CNT_W'(DW - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_WAIT_IDLE;
            cnt     <= '0;
            hdr_sh  <= '0;
            data_sh <= '0;
            idx_q   <= '0;
            is_read <= 1'b0;
        end else begin
            case (st)
                ST_WAIT_IDLE: begin
                    if (din) st <= ST_READY;
                end
                ST_READY: begin
                    if (!din) st <= ST_START;
                end
                ST_START: begin
                    cnt <= '0;
                    st  <= din ? ST_HDR : ST_WAIT_IDLE;
                end
                ST_HDR: begin
                    hdr_sh <= hdr_full;
                    if (cnt == CNT_W'(HW - 1)) begin
                        cnt <= '0;
                        if (hit) begin
                            st      <= ST_TURN;
                            idx_q   <= idx_f;
                            is_read <= (op_f == OPC_READ);
                        end else begin
                            st <= ST_SKIP;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_TURN: begin
                    if (cnt == CNT_W'(TURN_BITS - 1)) begin
                        cnt <= '0;
                        st  <= ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    data_sh <= {data_sh[DW-2:0], din};
                    if (data_last) begin
                        cnt <= '0;
                        st  <= ST_WAIT_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SKIP: begin
                    if (cnt == CNT_W'(SKIPN - 1)) begin
                        cnt <= '0;
                        st  <= ST_WAIT_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ST_WAIT_IDLE;
            endcase
        end
    end

    assign state     = st;
    assign reg_idx   = idx_q;
    assign wr_data   = {data_sh[DW-2:0], din};
    assign wr_en     = data_last && !is_read;
    assign drv_start = (st == ST_TURN) && (cnt == '0) && is_read;
    assign drv_stop  = data_last && is_read;

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_agent_pkg::*;
#(
    parameter int RAW = REG_ADDR_W,
    parameter int DW  = REG_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [RAW-1:0] idx,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata
);

    localparam int NREGS = 1 << RAW;

    logic [DW-1:0] bank [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= DW'(reg_reset_value(g));
            end else if (we && (idx == RAW'(g))) begin
                q <= wdata;
            end
        end
        assign bank[g] = q;
    end

    assign rdata = bank[idx];

endmodule

// File: rtl/mdio_line_driver.sv
module mdio_line_driver #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic [DW-1:0] load_word,
    output logic          line_out,
    output logic          line_oe
);

    logic [DW-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_oe  <= 1'b0;
            line_out <= 1'b0;
            sh       <= '0;
        end else if (start) begin
            line_oe  <= 1'b1;
            line_out <= 1'b0;
            sh       <= load_word;
        end else if (stop) begin
            line_oe  <= 1'b0;
            line_out <= 1'b0;
        end else if (line_oe) begin
            line_out <= sh[DW-1];
            sh       <= {sh[DW-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/mdio_mgmt_agent.sv
module mdio_mgmt_agent
    import mdio_agent_pkg::*;
#(
    parameter int AW  = DEV_ADDR_W,
    parameter int RAW = REG_ADDR_W,
    parameter int DW  = REG_W
) (
    input  logic          mdc,
    input  logic          rst,
    input  logic [AW-1:0] phy_addr_strap,
    input  logic          mdio_in,
    output logic          mdio_out,
    output logic          mdio_oe
);

    logic [AW-1:0]  addr_q;
    fsm_state_e     st;
    logic           wr_en;
    logic [RAW-1:0] reg_idx;
    logic [DW-1:0]  wr_data;
    logic [DW-1:0]  rd_data;
    logic           drv_start;
    logic           drv_stop;

    always_ff @(posedge mdc) begin
        if (rst) addr_q <= phy_addr_strap;
    end

    mdio_frame_fsm #(.AW(AW), .RAW(RAW), .DW(DW)) u_fsm (
        .clk       (mdc),
        .rst       (rst),
        .din       (mdio_in),
        .my_addr   (addr_q),
        .state     (st),
        .wr_en     (wr_en),
        .reg_idx   (reg_idx),
        .wr_data   (wr_data),
        .drv_start (drv_start),
        .drv_stop  (drv_stop)
    );

    mdio_reg_bank #(.RAW(RAW), .DW(DW)) u_bank (
        .clk   (mdc),
        .rst   (rst),
        .we    (wr_en),
        .idx   (reg_idx),
        .wdata (wr_data),
        .rdata (rd_data)
    );

    mdio_line_driver #(.DW(DW)) u_drv (
        .clk       (mdc),
        .rst       (rst),
        .start     (drv_start),
        .stop      (drv_stop),
        .load_word (rd_data),
        .line_out  (mdio_out),
        .line_oe   (mdio_oe)
    );

endmodule

// File: rtl/mdio_mgmt_agent_chk.sv
module mdio_mgmt_agent_chk
    import mdio_agent_pkg::*;
#(
    parameter int AW = DEV_ADDR_W
) (
    input logic          mdc,
    input logic          rst,
    input logic          mdio_oe,
    input logic          mdio_out,
    input fsm_state_e    st,
    input logic          wr_en,
    input logic [AW-1:0] addr_q
);

    logic [7:0] oe_run;

    always_ff @(posedge mdc) begin
        if (rst)          oe_run <= '0;
        else if (mdio_oe) oe_run <= oe_run + 1'b1;
        else              oe_run <= '0;
    end

    // R1: line released whenever the agent is between frames
    p_quiet_between_frames_r1: assert property (@(posedge mdc) disable iff (rst)
        ((st == ST_WAIT_IDLE) || (st == ST_READY)) |-> !mdio_oe);

    // R4: no drive in the cycle a write commits
    p_write_silent_r4: assert property (@(posedge mdc) disable iff (rst)
        wr_en |-> !mdio_oe);

    // R5: first driven bit is the low turnaround bit
    p_turn_low_r5: assert property (@(posedge mdc) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_out);

    // R5: drive window is turnaround plus data
    p_drive_len_r5: assert property (@(posedge mdc) disable iff (rst)
        $fell(mdio_oe) |-> (oe_run == 8'(DRIVE_BITS)));

    // R6: driving begins only from an accepted frame's turnaround
    p_drive_from_turn_r6: assert property (@(posedge mdc) disable iff (rst)
        $rose(mdio_oe) |-> (st == ST_TURN));

    // R8: latched address holds outside reset
    p_addr_hold_r8: assert property (@(posedge mdc) disable iff (rst)
        !$past(rst) |-> $stable(addr_q));

endmodule

bind mdio_mgmt_agent mdio_mgmt_agent_chk #(.AW(AW)) u_chk (
    .mdc      (mdc),
    .rst      (rst),
    .mdio_oe  (mdio_oe),
    .mdio_out (mdio_out),
    .st       (st),
    .wr_en    (wr_en),
    .addr_q   (addr_q)
);

// File: tb/mdio_mgmt_agent_test.sv
module mdio_mgmt_agent_test;

    logic       mdc = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] phy_addr_strap = 5'h01;
    logic       mdio_in = 1'b1;
    logic       mdio_out;
    logic       mdio_oe;

    int total = 0;
    int bad   = 0;

    logic [15:0] ref_regs [32];
    logic [4:0]  ref_addr;

    logic  pend_valid = 1'b0;
    logic  pend_oe;
    logic  pend_out;
    string pend_req;

    always #4 mdc = ~mdc;

    mdio_mgmt_agent uut (
        .mdc            (mdc),
        .rst            (rst),
        .phy_addr_strap (phy_addr_strap),
        .mdio_in        (mdio_in),
        .mdio_out       (mdio_out),
        .mdio_oe        (mdio_oe)
    );

    // Compare the outputs produced by the previous rising edge, then drive the next bit.
    task automatic send_bit(input logic b, input logic eoe, input logic eout, input string req);
        @(negedge mdc);
        if (pend_valid) begin
            total++;
            if (mdio_oe !== pend_oe || (pend_oe && mdio_out !== pend_out)) begin
                bad++;
                $display("FAIL %s: oe/out=%b/%b expected %b/%b at %0t",
                         pend_req, mdio_oe, mdio_out, pend_oe, pend_out, $time);
            end
        end
        mdio_in    = b;
        pend_oe    = eoe;
        pend_out   = eout;
        pend_req   = req;
        pend_valid = 1'b1;
    endtask

    task automatic do_reset(input logic [4:0] strap);
        @(negedge mdc);
        rst = 1'b1;
        phy_addr_strap = strap;
        mdio_in = 1'b1;
        pend_valid = 1'b0;
        repeat (3) @(negedge mdc);
        rst = 1'b0;
        ref_addr = strap;
        for (int i = 0; i < 32; i++) ref_regs[i] = (i == 0) ? 16'h1140 : 16'h0000;
        send_bit(1'b1, 1'b0, 1'b0, "R1");
    endtask

    task automatic frame(input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input int npre, input int nidle, input string req);
        logic hit;
        logic rd;
        logic [15:0] ev;
        hit = (pa == ref_addr) && (op == 2'b10 || op == 2'b01);
        rd  = hit && (op == 2'b10);
        ev  = ref_regs[ra];
        for (int i = 0; i < npre; i++) send_bit(1'b1, 1'b0, 1'b0, req);
        send_bit(1'b0, 1'b0, 1'b0, req);
        send_bit(1'b1, 1'b0, 1'b0, req);
        send_bit(op[1], 1'b0, 1'b0, req);
        send_bit(op[0], 1'b0, 1'b0, req);
        for (int i = 4; i >= 0; i--) send_bit(pa[i], 1'b0, 1'b0, req);
        for (int i = 4; i >= 0; i--) send_bit(ra[i], 1'b0, 1'b0, req);
        send_bit(1'b1, rd, 1'b0, req);
        send_bit(rd ? 1'b1 : 1'b0, rd, ev[15], req);
        for (int j = 0; j < 16; j++) begin
            if (j < 15) send_bit(rd ? 1'b1 : wd[15-j], rd, ev[14-j], req);
            else        send_bit(rd ? 1'b1 : wd[0], 1'b0, 1'b0, req);
        end
        for (int i = 0; i < nidle; i++) send_bit(1'b1, 1'b0, 1'b0, req);
        if (hit && op == 2'b01) ref_regs[ra] = wd;
    endtask

    initial begin
        repeat (200000) @(posedge mdc);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset(5'h01);
        // R1: reset values, no preamble
        frame(2'b10, 5'h01, 5'h00, 16'h0, 0, 1, "R1");
        frame(2'b10, 5'h01, 5'h07, 16'h0, 0, 1, "R1");
        // R4 write, R5 readback
        frame(2'b01, 5'h01, 5'h03, 16'hA5C3, 0, 1, "R4");
        frame(2'b10, 5'h01, 5'h03, 16'h0, 0, 1, "R5");
        // R2: back-to-back frames with exactly one idle bit
        frame(2'b01, 5'h01, 5'h09, 16'hFFFF, 0, 1, "R2");
        frame(2'b10, 5'h01, 5'h09, 16'h0, 0, 1, "R2");
        frame(2'b01, 5'h01, 5'h1F, 16'h8001, 0, 1, "R2");
        frame(2'b10, 5'h01, 5'h1F, 16'h0, 0, 1, "R2");
        frame(2'b01, 5'h01, 5'h09, 16'h0000, 0, 1, "R2");
        frame(2'b10, 5'h01, 5'h09, 16'h0, 0, 1, "R2");
        // R3: full preamble
        frame(2'b10, 5'h01, 5'h03, 16'h0, 32, 1, "R3");
        frame(2'b01, 5'h01, 5'h11, 16'h5A0F, 32, 1, "R3");
        frame(2'b10, 5'h01, 5'h11, 16'h0, 33, 1, "R3");
        // R6: other addresses are silent and do not write
        frame(2'b01, 5'h02, 5'h03, 16'h1234, 0, 1, "R6");
        frame(2'b10, 5'h02, 5'h03, 16'h0, 0, 1, "R6");
        frame(2'b10, 5'h11, 5'h00, 16'h0, 0, 1, "R6");
        frame(2'b10, 5'h01, 5'h03, 16'h0, 0, 1, "R6");
        // R7: reserved opcodes
        frame(2'b00, 5'h01, 5'h03, 16'hDEAD, 0, 1, "R7");
        frame(2'b11, 5'h01, 5'h03, 16'hBEEF, 0, 1, "R7");
        frame(2'b10, 5'h01, 5'h03, 16'h0, 0, 1, "R7");
        // R8: strap change after reset has no effect
        phy_addr_strap = 5'h02;
        frame(2'b10, 5'h01, 5'h03, 16'h0, 0, 1, "R8");
        frame(2'b10, 5'h02, 5'h03, 16'h0, 0, 1, "R8");
        // R8: new reset latches a new address and restores reset values
        do_reset(5'h1F);
        frame(2'b10, 5'h01, 5'h00, 16'h0, 0, 1, "R8");
        frame(2'b10, 5'h1F, 5'h03, 16'h0, 0, 1, "R8");
        frame(2'b10, 5'h1F, 5'h00, 16'h0, 0, 2, "R8");
        send_bit(1'b1, 1'b0, 1'b0, "R1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule